// File: doc/BRIEF.md
# Polarity-Steered Bridgeless Boost PWM

This block produces the four gate commands of a bridgeless totem-pole boost rectifier. Two fast switches form a complementary pair driven at the PWM carrier rate (50 kHz with the default period at a 125 MHz system clock). Two slow rectifier switches are switched at line frequency and follow the AC half cycle. An external current loop supplies a duty word in system clocks, a sampler supplies one bit giving the sign of the line voltage, and a global enable gates the whole output stage.

The sign bit must hold its new value across several carrier periods before a half-cycle change is taken. On each accepted change, both slow switches are held off for a guard interval. The fast pair is also held off for that interval. Then the roles of the fast switches are exchanged: in the positive half the lower fast switch is the boost switch and the upper one freewheels, and in the negative half the reverse holds. The duty cap then ramps up from zero over a few carrier periods, so the boost switch never jumps from almost zero to almost full conduction. The same soft ramp and guard are applied after reset and whenever enable returns high.

Top module: `pfc_steer_pwm`

## Requirements
- R1: The carrier period is PERIOD system clocks. In steady state the boost switch is on for duty−DEAD clocks and the freewheel switch for PERIOD−duty−DEAD clocks of every period, when DEAD < duty < PERIOD−DEAD.
- R2: With the accepted half cycle positive (linePositive = 1), slowPos is on and slowNeg is off. With it negative, slowNeg is on and slowPos is off. The two are never on together.
- R3: In the positive half cycle gateLo carries the boost pulse and gateHi the complementary freewheel pulse. In the negative half cycle gateHi carries the boost pulse and gateLo the freewheel pulse.
- R4: gateHi and gateLo are never on together. Each turns on only after the other has been off for at least DEAD clocks.
- R5: A duty word above PERIOD is clamped to PERIOD, which leaves the boost switch on for the whole period and the freewheel switch off.
- R6: The duty word is sampled only in the last clock of each carrier period. A change during a period does not alter that period's pulse.
- R7: A half-cycle change is accepted only after linePositive has differed from the accepted polarity at DEB_PERIODS consecutive period ends. A shorter excursion has no effect.
- R8: At each accepted change, and after reset or re-enable, both slow switches stay off for GUARD clocks before the new one turns on.
- R9: The duty cap is zero in the period in which a change is accepted. It then rises by RAMP_STEP each period until it reaches PERIOD. The effective duty is the smaller of the duty word and the cap.
- R10: While reset is active all four gates are off. When enable is low, all four gates are off from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Global gate enable |
| dutyCmd | input | DUTY_W | Boost on-time request in system clocks |
| linePositive | input | 1 | Sampled line sign, 1 = positive half cycle |
| gateHi | output | 1 | Upper fast switch gate |
| gateLo | output | 1 | Lower fast switch gate |
| slowPos | output | 1 | Slow rectifier switch for the positive half |
| slowNeg | output | 1 | Slow rectifier switch for the negative half |

## Verification
The guard assertions count off-time only from the gate outputs. They therefore rely on every slow-switch turn-on following a reset, a re-enable or an accepted change, all of which reload the guard. The stimulus drives enable only after reset has released and keeps it low for many clocks. The dead-time checks assume that the raw complementary commands never request both fast switches at once. The stimulus keeps RAMP_STEP no larger than PERIOD and changes the line sign and the duty word only at falling clock edges, so every sampled input is stable at the sampling edge.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  // Strobes from the control section to the datapath
  typedef struct packed {
    logic periodEnd;  // last clock of the carrier period
    logic flip;       // half-cycle change accepted this clock
    logic guardOn;    // changeover guard running
    logic polarity;   // accepted half cycle, 1 = positive
  } pfcStrobes_t;
endpackage

// File: rtl/pfc_ctrl.sv
module pfc_ctrl
  import pfc_pkg::*;
#(
  parameter int PERIOD      = 2500,
  parameter int DEB_PERIODS = 4,
  parameter int GUARD       = 250,
  parameter int RAMP_STEP   = 500,
  parameter int CNT_W       = $clog2(PERIOD + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             linePositive,
  output logic [CNT_W-1:0] carrierCnt,
  output logic [CNT_W-1:0] dutyCap,
  output pfcStrobes_t      st
);
  localparam int DEB_W = $clog2(DEB_PERIODS + 1);
  localparam int GRD_W = $clog2(GUARD + 1);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] PER_V  = CNT_W'(PERIOD);
  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(RAMP_STEP);
  localparam logic [CNT_W-1:0] HEAD_V = CNT_W'(PERIOD - RAMP_STEP);
  localparam logic [DEB_W-1:0] DEB_LAST = DEB_W'(DEB_PERIODS - 1);
  localparam logic [GRD_W-1:0] GRD_V = GRD_W'(GUARD);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] rampLim;
  logic [DEB_W-1:0] debCnt;
  logic [GRD_W-1:0] guardCnt;
  logic             polAcc;
  logic             periodEnd;
  logic             mismatch;
  logic             flip;

  assign periodEnd = (cnt == LAST);
  assign mismatch  = linePositive ^ polAcc;
  assign flip      = periodEnd & mismatch & (debCnt == DEB_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      polAcc   <= 1'b1;
      debCnt   <= '0;
      guardCnt <= GRD_V;
      rampLim  <= '0;
    end else begin
      cnt <= periodEnd ? '0 : cnt + 1'b1;

      // debounce counted in carrier periods
      if (periodEnd) begin
        if (!mismatch)  debCnt <= '0;
        else if (flip) begin
          polAcc <= linePositive;
          debCnt <= '0;
        end else        debCnt <= debCnt + 1'b1;
      end

      // changeover guard, re-armed while disabled
      if (!enable || flip)     guardCnt <= GRD_V;
      else if (guardCnt != '0) guardCnt <= guardCnt - 1'b1;

      // soft-start cap, restarted on every change
      if (!enable)        rampLim <= '0;
      else if (flip)      rampLim <= STEP_V;
      else if (periodEnd) rampLim <= (rampLim >= HEAD_V) ? PER_V : rampLim + STEP_V;
    end
  end

  assign carrierCnt   = cnt;
  assign dutyCap      = flip ? '0 : rampLim;
  assign st.periodEnd = periodEnd;
  assign st.flip      = flip;
  assign st.guardOn   = (guardCnt != '0);
  assign st.polarity  = polAcc;
endmodule

// File: rtl/pfc_deadband.sv
module pfc_deadband #(
  parameter int DEAD = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic rawOn,
  output logic gateOn
);
  localparam int DW = $clog2(DEAD + 2);
  localparam logic [DW-1:0] DEAD_V = DW'(DEAD);

  logic [DW-1:0] waitCnt;

  // turn-on is delayed by DEAD clocks, turn-off is immediate
  always_ff @(posedge clk) begin
    if (rst || !enable || !rawOn) begin
      waitCnt <= '0;
      gateOn  <= 1'b0;
    end else if (waitCnt == DEAD_V) begin
      gateOn  <= 1'b1;
    end else begin
      waitCnt <= waitCnt + 1'b1;
    end
  end
endmodule

// File: rtl/pfc_datapath.sv
module pfc_datapath
  import pfc_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int DUTY_W = 12,
  parameter int DEAD   = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [DUTY_W-1:0] dutyCmd,
  input  logic [CNT_W-1:0]  dutyCap,
  input  logic [CNT_W-1:0]  carrierCnt,
  input  pfcStrobes_t       st,
  output logic              gateHi,
  output logic              gateLo,
  output logic              slowPos,
  output logic              slowNeg
);
  localparam int CMP_W = (DUTY_W > CNT_W) ? DUTY_W : CNT_W;

  logic [CMP_W-1:0] cmdW, capW, pick;
  logic [CNT_W-1:0] dutyLat;
  logic             mainOn;
  logic [1:0]       rawGate;  // [0] lower, [1] upper
  logic [1:0]       gateVec;

  assign cmdW = CMP_W'(dutyCmd);
  assign capW = CMP_W'(dutyCap);
  assign pick = (cmdW < capW) ? cmdW : capW;

  always_ff @(posedge clk) begin
    if (rst)               dutyLat <= '0;
    else if (st.periodEnd) dutyLat <= CNT_W'(pick);
  end

  assign mainOn = (carrierCnt < dutyLat);

  always_comb begin
    if (st.guardOn)     rawGate = 2'b00;
    else if (st.polarity) rawGate = {~mainOn, mainOn};
    else                rawGate = {mainOn, ~mainOn};
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_fast
    pfc_deadband #(.DEAD(DEAD)) u_db (
      .clk    (clk),
      .rst    (rst),
      .enable (enable),
      .rawOn  (rawGate[ch]),
      .gateOn (gateVec[ch])
    );
  end

  assign gateLo = gateVec[0];
  assign gateHi = gateVec[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      slowPos <= 1'b0;
      slowNeg <= 1'b0;
    end else begin
      slowPos <= enable &  st.polarity & ~st.guardOn;
      slowNeg <= enable & ~st.polarity & ~st.guardOn;
    end
  end
endmodule

// File: rtl/pfc_steer_pwm.sv
module pfc_steer_pwm
  import pfc_pkg::*;
#(
  parameter int PERIOD      = 2500,
  parameter int DUTY_W      = 12,
  parameter int DEAD        = 25,
  parameter int DEB_PERIODS = 4,
  parameter int GUARD       = 250,
  parameter int RAMP_STEP   = 500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [DUTY_W-1:0] dutyCmd,
  input  logic              linePositive,
  output logic              gateHi,
  output logic              gateLo,
  output logic              slowPos,
  output logic              slowNeg
);
  localparam int CNT_W = $clog2(PERIOD + 1);

  logic [CNT_W-1:0] carrierCnt;
  logic [CNT_W-1:0] dutyCap;
  pfcStrobes_t      st;

  pfc_ctrl #(
    .PERIOD(PERIOD), .DEB_PERIODS(DEB_PERIODS), .GUARD(GUARD),
    .RAMP_STEP(RAMP_STEP), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .linePositive(linePositive),
    .carrierCnt(carrierCnt), .dutyCap(dutyCap), .st(st)
  );

  pfc_datapath #(
    .CNT_W(CNT_W), .DUTY_W(DUTY_W), .DEAD(DEAD)
  ) u_dp (
    .clk(clk), .rst(rst), .enable(enable), .dutyCmd(dutyCmd),
    .dutyCap(dutyCap), .carrierCnt(carrierCnt), .st(st),
    .gateHi(gateHi), .gateLo(gateLo), .slowPos(slowPos), .slowNeg(slowNeg)
  );
endmodule

// File: rtl/pfc_steer_pwm_chk.sv
module pfc_steer_pwm_chk #(
  parameter int DEAD  = 25,
  parameter int GUARD = 250
) (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic gateHi,
  input logic gateLo,
  input logic slowPos,
  input logic slowNeg
);
  localparam int DW = $clog2(DEAD + 2);
  localparam int GW = $clog2(GUARD + 2);
  localparam logic [DW-1:0] DEAD_V  = DW'(DEAD);
  localparam logic [GW-1:0] GUARD_V = GW'(GUARD);

  logic [DW-1:0] loOff, hiOff;
  logic [GW-1:0] slowOff;

  always_ff @(posedge clk) begin
    if (rst || gateLo)       loOff <= '0;
    else if (loOff < DEAD_V) loOff <= loOff + 1'b1;
    if (rst || gateHi)       hiOff <= '0;
    else if (hiOff < DEAD_V) hiOff <= hiOff + 1'b1;
    if (rst || slowPos || slowNeg) slowOff <= '0;
    else if (slowOff < GUARD_V)    slowOff <= slowOff + 1'b1;
  end

  p_fast_excl_r4: assert property (@(posedge clk) disable iff (rst) !(gateHi && gateLo));
  p_dead_hi_r4:   assert property (@(posedge clk) disable iff (rst) $rose(gateHi) |-> (loOff >= DEAD_V));
  p_dead_lo_r4:   assert property (@(posedge clk) disable iff (rst) $rose(gateLo) |-> (hiOff >= DEAD_V));
  p_slow_excl_r2: assert property (@(posedge clk) disable iff (rst) !(slowPos && slowNeg));
  p_guard_pos_r8: assert property (@(posedge clk) disable iff (rst) $rose(slowPos) |-> (slowOff >= GUARD_V));
  p_guard_neg_r8: assert property (@(posedge clk) disable iff (rst) $rose(slowNeg) |-> (slowOff >= GUARD_V));
  p_en_off_r10:   assert property (@(posedge clk) disable iff (rst)
                    !$past(enable) |-> !(gateHi || gateLo || slowPos || slowNeg));
endmodule

bind pfc_steer_pwm pfc_steer_pwm_chk #(.DEAD(DEAD), .GUARD(GUARD)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .gateHi(gateHi), .gateLo(gateLo),
  .slowPos(slowPos), .slowNeg(slowNeg)
);

// File: tb/sim_pfc_steer_pwm.sv
module sim_pfc_steer_pwm;
  localparam int PERIOD = 40;
  localparam int DUTY_W = 8;
  localparam int DEAD   = 3;
  localparam int DEB    = 2;
  localparam int GUARD  = 5;
  localparam int STEP   = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic [DUTY_W-1:0] dutyCmd = 8'd20;
  logic linePositive = 1'b1;
  logic gateHi, gateLo, slowPos, slowNeg;

  int compared = 0;
  int mismatched = 0;
  int overlaps = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pfc_steer_pwm #(
    .PERIOD(PERIOD), .DUTY_W(DUTY_W), .DEAD(DEAD), .DEB_PERIODS(DEB),
    .GUARD(GUARD), .RAMP_STEP(STEP)
  ) u0 (
    .clk(clk), .rst(rst), .enable(enable), .dutyCmd(dutyCmd),
    .linePositive(linePositive), .gateHi(gateHi), .gateLo(gateLo),
    .slowPos(slowPos), .slowNeg(slowNeg)
  );

  always @(negedge clk)
    if (!rst && ((gateHi && gateLo) || (slowPos && slowNeg))) overlaps++;

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(output int hiN, output int loN, output int spN, output int snN);
    hiN = 0; loN = 0; spN = 0; snN = 0;
    for (int i = 0; i < PERIOD; i++) begin
      @(negedge clk);
      hiN += int'(gateHi); loN += int'(gateLo);
      spN += int'(slowPos); snN += int'(slowNeg);
    end
  endtask

  task automatic t_reset();
    waitClk(5);
    chk("R10", "gates during reset", int'({gateHi, gateLo, slowPos, slowNeg}), 0);
    rst = 1'b0;
    enable = 1'b1;
    waitClk(12 * PERIOD);
  endtask

  task automatic t_positive();
    int h, l, sp, sn;
    dutyCmd = 8'd20; waitClk(3 * PERIOD);
    measure(h, l, sp, sn);
    chk("R3", "pos duty20 gateLo", l, 20 - DEAD);
    chk("R1", "pos duty20 gateHi", h, PERIOD - 20 - DEAD);
    chk("R2", "pos slowPos", sp, PERIOD);
    chk("R2", "pos slowNeg", sn, 0);
    dutyCmd = 8'd30; waitClk(3 * PERIOD);
    measure(h, l, sp, sn);
    chk("R3", "pos duty30 gateLo", l, 30 - DEAD);
    chk("R1", "pos duty30 gateHi", h, PERIOD - 30 - DEAD);
  endtask

  task automatic t_clamp();
    int h, l, sp, sn;
    dutyCmd = 8'd60; waitClk(3 * PERIOD);
    measure(h, l, sp, sn);
    chk("R5", "clamped gateLo", l, PERIOD);
    chk("R5", "clamped gateHi", h, 0);
  endtask

  task automatic t_boundary();
    int l;
    dutyCmd = 8'd20; waitClk(3 * PERIOD);
    @(posedge gateLo);
    l = 0;
    for (int i = 0; i < PERIOD; i++) begin
      @(negedge clk);
      dutyCmd = (i < 20) ? 8'd5 : 8'd20;
      l += int'(gateLo);
    end
    chk("R6", "mid-period duty change", l, 20 - DEAD);
  endtask

  task automatic t_enable();
    @(negedge clk);
    chk("R2", "slowPos before disable", int'(slowPos), 1);
    enable = 1'b0;
    @(negedge clk);
    chk("R10", "gates after disable", int'({gateHi, gateLo, slowPos, slowNeg}), 0);
    waitClk(PERIOD);
    chk("R10", "gates while disabled", int'({gateHi, gateLo, slowPos, slowNeg}), 0);
    enable = 1'b1;
    waitClk(12 * PERIOD);
  endtask

  task automatic t_debounce();
    int low = 0;
    @(negedge clk);
    linePositive = 1'b0;
    for (int i = 0; i < PERIOD; i++) begin
      @(negedge clk);
      low += int'(!slowPos);
    end
    linePositive = 1'b1;
    for (int i = 0; i < 3 * PERIOD; i++) begin
      @(negedge clk);
      low += int'(!slowPos) + int'(slowNeg);
    end
    chk("R7", "short polarity excursion", low, 0);
  endtask

  task automatic t_flip_neg();
    int off = 0, hiSum = 0, h, l, sp, sn, guardWait = 0;
    dutyCmd = 8'd30;
    waitClk(2 * PERIOD);
    linePositive = 1'b0;
    while (!slowNeg && guardWait < 8 * PERIOD) begin
      @(negedge clk);
      guardWait++;
      if (!slowPos && !slowNeg) off++;
    end
    chk("R7", "change accepted", int'(slowNeg), 1);
    chk("R8", "guard pos->neg", off, GUARD);
    hiSum = int'(gateHi);
    for (int i = 1; i < 5 * PERIOD; i++) begin
      @(negedge clk);
      hiSum += int'(gateHi);
    end
    chk("R9", "soft ramp boost on-time", hiSum, 80);
    waitClk(2 * PERIOD);
    measure(h, l, sp, sn);
    chk("R3", "neg duty30 gateHi", h, 30 - DEAD);
    chk("R3", "neg duty30 gateLo", l, PERIOD - 30 - DEAD);
    chk("R2", "neg slowNeg", sn, PERIOD);
    chk("R2", "neg slowPos", sp, 0);
  endtask

  task automatic t_flip_pos();
    int off = 0, guardWait = 0;
    linePositive = 1'b1;
    while (!slowPos && guardWait < 8 * PERIOD) begin
      @(negedge clk);
      guardWait++;
      if (!slowPos && !slowNeg) off++;
    end
    chk("R8", "guard neg->pos", off, GUARD);
    waitClk(6 * PERIOD);
  endtask

  initial begin
    t_reset();
    t_positive();
    t_clamp();
    t_boundary();
    t_enable();
    t_debounce();
    t_flip_neg();
    t_flip_pos();
    chk("R4", "fast or slow pair overlap cycles", overlaps, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule